// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor core into one of two exceptions: a hardware interrupt, requested by a level on `irq_req`, or a software interrupt, signalled by a pulse from the decoder on `swi_req`. The core supplies three inputs: its current program counter, its current status word and a flag that shows whether it is executing the compact (2-byte) instruction set. When an exception is accepted, the block registers a complete entry record and raises `flush` for one cycle. The core uses that cycle to discard its pipeline and load the record. The record holds the new mode, the link register value, the new program counter, the status word to save, and the updated status word.

The saved return address depends on two things: the kind of exception and the instruction width of the state being left. Both kinds of entry mask further interrupts and put the core in the wide (4-byte) instruction state. The status word layout used throughout is fixed: the mode is in bits [4:0], the interrupt-disable bit is bit 7, and the compact-state bit is bit 5.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `flush` is 0 and every record output is zero until the first accepted exception.
- R2: When `irq_req` is high, bit 7 of `psr_in` is 0 and `flush` is low at a rising edge, `flush` is 1 after that edge and `new_mode` holds the interrupt mode 0x12.
- R3: When bit 7 of `psr_in` is 1, `irq_req` is not accepted: `flush` stays 0 and every record output keeps its previous value.
- R4: When `swi_req` is high and `flush` is low at a rising edge, the software interrupt is accepted whatever the value of bit 7, and `new_mode` becomes the supervisor mode 0x13.
- R5: On interrupt entry, `link_out` = `pc_in` − w + 4, where w is 2 when `compact` is 1 and 4 otherwise.
- R6: On software-interrupt entry, `link_out` = `pc_in` − w, with w as in R5.
- R7: `pc_out` is set to 0x0000_001C on interrupt entry and to 0x0000_000C on software-interrupt entry. These are the vector addresses 0x18 and 0x08, each plus 4 for the prefetch offset.
- R8: `spsr_out` is set to the value `psr_in` had at the accepting edge.
- R9: `psr_out` is set to `psr_in` with bits [4:0] replaced by the new mode, bit 7 set and bit 5 cleared, and all other bits unchanged.
- R10: `flush` is high for exactly one cycle per entry. No request is accepted while `flush` is high. All record outputs hold their values between entries.
- R11: When both requests are present at the same edge, only the software interrupt is taken. After the core loads the masked status, the still-pending interrupt is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Hardware interrupt request level |
| swi_req | input | 1 | Software-interrupt request from decode |
| pc_in | input | 32 | Current program counter |
| psr_in | input | 32 | Current status word |
| compact | input | 1 | Core is executing 2-byte instructions |
| flush | output | 1 | One-cycle pipeline flush on entry |
| new_mode | output | 5 | Mode entered |
| link_out | output | 32 | Value for the new mode's link register |
| pc_out | output | 32 | New program counter |
| spsr_out | output | 32 | Status word to save for the new mode |
| psr_out | output | 32 | Updated status word |

## Verification
The assertions assume that the core loads `psr_out` into `psr_in` during the flush cycle. The interrupt-blocking property is written on the current `psr_in` only, so it does not depend on earlier cycles. The assertions also assume that `swi_req` reflects a decoded instruction and is never X after reset. The stimulus follows these assumptions. It changes inputs only on falling edges, it returns the requests to idle after each sampled entry, and after a combined request it presents the masked status word exactly as a core would.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN = 32,
  parameter int MODE_W = 5,
  parameter int IDIS_BIT = 7,
  parameter int CSTATE_BIT = 5,
  parameter logic [MODE_W-1:0] IRQ_MODE = 5'h12,
  parameter logic [MODE_W-1:0] SVC_MODE = 5'h13,
  parameter logic [XLEN-1:0] IRQ_VEC = 32'h18,
  parameter logic [XLEN-1:0] SWI_VEC = 32'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              swi_req,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   psr_in,
  input  logic              compact,
  output logic              flush,
  output logic [MODE_W-1:0] new_mode,
  output logic [XLEN-1:0]   link_out,
  output logic [XLEN-1:0]   pc_out,
  output logic [XLEN-1:0]   spsr_out,
  output logic [XLEN-1:0]   psr_out
);

  localparam logic [XLEN-1:0] WIDE_STEP   = XLEN'(4);
  localparam logic [XLEN-1:0] NARROW_STEP = XLEN'(2);
  localparam logic [XLEN-1:0] PREFETCH    = XLEN'(4);

  logic              swi_go, irq_go, take;
  logic [XLEN-1:0]   step, link_n, pc_n, psr_n;
  logic [MODE_W-1:0] mode_n;

  assign swi_go = swi_req && !flush;
  assign irq_go = irq_req && !psr_in[IDIS_BIT] && !flush;
  assign take   = swi_go || irq_go;

  assign step   = compact ? NARROW_STEP : WIDE_STEP;
  assign mode_n = swi_go ? SVC_MODE : IRQ_MODE;
  assign link_n = swi_go ? (pc_in - step) : (pc_in - step + PREFETCH);
  assign pc_n   = (swi_go ? SWI_VEC : IRQ_VEC) + PREFETCH;

  always_comb begin
    psr_n               = psr_in;
    psr_n[MODE_W-1:0]   = mode_n;
    psr_n[IDIS_BIT]     = 1'b1;
    psr_n[CSTATE_BIT]   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush    <= 1'b0;
      new_mode <= '0;
      link_out <= '0;
      pc_out   <= '0;
      spsr_out <= '0;
      psr_out  <= '0;
    end else begin
      flush <= take;
      if (take) begin
        new_mode <= mode_n;
        link_out <= link_n;
        pc_out   <= pc_n;
        spsr_out <= psr_in;
        psr_out  <= psr_n;
      end
    end
  end

  assert_flush_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  assert_masked_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && psr_in[IDIS_BIT] && !swi_req && !flush) |=> !flush);

  assert_swi_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_req && !flush) |=> (flush && new_mode == SVC_MODE));

  assert_spsr_saved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_req && !flush) |=> (spsr_out == $past(psr_in)));

  assert_psr_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (psr_out[IDIS_BIT] && !psr_out[CSTATE_BIT] && psr_out[MODE_W-1:0] == new_mode));

  assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (pc_out == ((new_mode == SVC_MODE) ? SWI_VEC + PREFETCH : IRQ_VEC + PREFETCH)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !swi_req && !irq_req) |=> $stable(link_out) && $stable(pc_out) && $stable(new_mode));

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        irq;
    logic        swi;
    logic        cmp;
    logic [31:0] pc;
    logic [31:0] psr;
    logic        take;
    logic [4:0]  mode;
    logic [31:0] lr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 32'h0000_0100, 32'h0000_001F, 1'b1, 5'h12, 32'h0000_0100},
    '{1'b1, 1'b0, 1'b1, 32'h0000_0200, 32'h0000_003F, 1'b1, 5'h12, 32'h0000_0202},
    '{1'b1, 1'b0, 1'b0, 32'h0000_0250, 32'h0000_009F, 1'b0, 5'h00, 32'h0000_0000},
    '{1'b0, 1'b1, 1'b0, 32'h0000_0300, 32'h0000_009F, 1'b1, 5'h13, 32'h0000_02FC},
    '{1'b0, 1'b1, 1'b1, 32'h0000_0400, 32'h0000_003F, 1'b1, 5'h13, 32'h0000_03FE},
    '{1'b1, 1'b1, 1'b0, 32'h0000_0500, 32'h6000_001F, 1'b1, 5'h13, 32'h0000_04FC},
    '{1'b1, 1'b0, 1'b0, 32'h0000_0010, 32'hF000_0010, 1'b1, 5'h12, 32'h0000_0010}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 1'b0, swi_req = 1'b0, compact = 1'b0;
  logic [31:0] pc_in = '0, psr_in = '0;
  logic flush;
  logic [4:0] new_mode;
  logic [31:0] link_out, pc_out, spsr_out, psr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_req(swi_req),
    .pc_in(pc_in), .psr_in(psr_in), .compact(compact), .flush(flush),
    .new_mode(new_mode), .link_out(link_out), .pc_out(pc_out),
    .spsr_out(spsr_out), .psr_out(psr_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] masked(input logic [31:0] p, input logic [4:0] m);
    return (p & ~32'h0000_00BF) | 32'h0000_0080 | {27'd0, m};
  endfunction

  task automatic idle();
    irq_req = 1'b0; swi_req = 1'b0;
  endtask

  initial begin
    logic [31:0] h_lr, h_pc, h_spsr, h_psr;
    logic [4:0]  h_mode;
    repeat (2) @(negedge clk);
    check("R1 flush in reset", {31'd0, flush}, 32'd0);
    check("R1 link in reset", link_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flush after reset", {31'd0, flush}, 32'd0);
    check("R1 pc_out after reset", pc_out, 32'd0);
    check("R1 psr_out after reset", psr_out, 32'd0);

    for (int i = 0; i < NV; i++) begin
      h_lr = link_out; h_pc = pc_out; h_spsr = spsr_out; h_psr = psr_out; h_mode = new_mode;
      irq_req = VECS[i].irq; swi_req = VECS[i].swi; compact = VECS[i].cmp;
      pc_in = VECS[i].pc; psr_in = VECS[i].psr;
      @(negedge clk);
      if (VECS[i].take) begin
        check("R2/R4 flush raised", {31'd0, flush}, 32'd1);
        check("R2/R4/R11 new_mode", {27'd0, new_mode}, {27'd0, VECS[i].mode});
        check(VECS[i].mode == 5'h12 ? "R5 irq link" : "R6 swi link", link_out, VECS[i].lr);
        check("R7 vector", pc_out, VECS[i].mode == 5'h12 ? 32'h1C : 32'h0C);
        check("R8 saved status", spsr_out, VECS[i].psr);
        check("R9 new status", psr_out, masked(VECS[i].psr, VECS[i].mode));
        psr_in = psr_out;
        @(negedge clk);
        check("R10 flush one cycle", {31'd0, flush}, 32'd0);
        if (VECS[i].irq && VECS[i].swi) begin
          check("R11 pending irq blocked", {31'd0, flush}, 32'd0);
          check("R11 mode kept", {27'd0, new_mode}, 32'h13);
        end
      end else begin
        check("R3 no flush", {31'd0, flush}, 32'd0);
        check("R3 link held", link_out, h_lr);
        check("R3 pc held", pc_out, h_pc);
        check("R3 spsr held", spsr_out, h_spsr);
        check("R3 psr held", psr_out, h_psr);
        check("R3 mode held", {27'd0, new_mode}, {27'd0, h_mode});
      end
      idle();
      @(negedge clk);
      check("R10 idle no flush", {31'd0, flush}, 32'd0);
    end

    swi_req = 1'b1; compact = 1'b0; pc_in = 32'h0000_0800; psr_in = 32'h0000_0010;
    @(negedge clk);
    check("R4 swi taken", {31'd0, flush}, 32'd1);
    psr_in = 32'h0000_0810;
    @(negedge clk);
    check("R10 no accept during flush", {31'd0, flush}, 32'd1 ^ 32'd1);
    check("R10 saved status unchanged", spsr_out, 32'h0000_0010);
    @(negedge clk);
    check("R10 held swi taken after flush", {31'd0, flush}, 32'd1);
    check("R8 second saved status", spsr_out, 32'h0000_0810);
    idle();
    @(negedge clk);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears flush", {31'd0, flush}, 32'd0);
    check("R1 reset clears link", link_out, 32'd0);
    check("R1 reset clears spsr", spsr_out, 32'd0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule